// File: doc/BRIEF.md
# Synthesizer Channel Programming Sequencer

This block retunes a serially programmed frequency synthesizer. A one-cycle start pulse carries a channel number. The block then writes seven configuration registers over a three-wire link made of a serial clock, an active-low enable and a data line. The block works out the RF main divider from the channel number. Every other write carries a fixed value that is set by a parameter.

Each write is a 22-bit frame. The frame holds an 18-bit value above a 4-bit register address and is shifted out most-significant bit first. The serial clock is made by dividing the system clock, so each half period lasts a parameterized number of system cycles. The enable line goes high between frames for at least a parameterized number of cycles. When the last frame has ended and enable is high again, a one-cycle done pulse is raised. Start pulses that arrive while a sequence is running are dropped.

Top module: `synth_chan_seq`

## Requirements
- R1: Each write holds enable low for exactly 22 serial-clock rising edges. The bits captured on those edges, first bit most significant, form `{value[17:0], address[3:0]}`.
- R2: One sequence makes exactly seven writes, at these default addresses and in this order:
  - main configuration (0)
  - power-down control (2)
  - phase-detector gain (1)
  - RF N divider (4)
  - IF N divider (5)
  - RF R divider (7)
  - IF R divider (8)
- R3: The RF N value is 2033 + 5 × channel for every channel code 0..31, except channel 14, which uses 2110.
- R4: The fixed writes carry these default values:
  - main configuration: 0x00008 (reference divide-by-2 bit)
  - power-down control: 0x00003 (IF and RF sections enabled)
  - phase-detector gain: 0
  - IF N divider: 1496
  - RF R divider: 44
  - IF R divider: 44
- R5: Each serial-clock level lasts at least HALF_DIV system cycles, with a default of 4 (40 ns at 100 MHz per half period). The data line changes only while the serial clock is low.
- R6: Between two frames of a sequence, enable stays high for at least GAP system cycles (default 2).
- R7: Whenever enable is high, the serial clock and the data line are both low.
- R8: done_o pulses high for exactly one cycle per sequence. The pulse comes after the seventh frame, with enable high. busy_o is high from the accepted start until that pulse.
- R9: A start pulse is ignored while busy_o is high. The channel is captured when a start is accepted and is used for the whole sequence.
- R10: After reset, enable is high, the serial clock, the data line, busy_o and done_o are low, and no frame is sent until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program a channel |
| chan_i | input | 5 | Channel number, sampled with an accepted start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sen_n_o | output | 1 | Active-low frame enable |
| sdata_o | output | 1 | Serial data, valid on the rising serial clock |

## Verification
The bench runs the full sequence for every channel code from 0 to 31 and decodes each frame from the serial lines. This sweep separates the linear divider formula from the channel-14 exception and catches errors in the address, the order and the bit order. Timing monitors measure the serial-clock half periods, the enable gap between frames and the idle line levels on every frame. A second start with a different channel is sent in the middle of a sequence. The frames must still carry the first channel, and no extra frames may follow, which shows that the channel is held and that starts during a sequence are ignored.

// File: rtl/synth_chan_seq.sv
module synth_chan_seq #(
  parameter int HALF_DIV   = 4,
  parameter int GAP        = 2,
  parameter int CH_W       = 5,
  parameter int VAL_W      = 18,
  parameter int ADR_W      = 4,
  parameter int N_BASE     = 2033,
  parameter int N_STEP     = 5,
  parameter int SPECIAL_CH = 14,
  parameter int SPECIAL_N  = 2110,
  parameter logic [VAL_W-1:0] MAIN_VAL = 18'h00008,
  parameter logic [VAL_W-1:0] PWR_VAL  = 18'h00003,
  parameter logic [VAL_W-1:0] PDG_VAL  = 18'h00000,
  parameter logic [VAL_W-1:0] IFN_VAL  = 18'd1496,
  parameter logic [VAL_W-1:0] RFR_VAL  = 18'd44,
  parameter logic [VAL_W-1:0] IFR_VAL  = 18'd44,
  parameter logic [ADR_W-1:0] MAIN_ADR = 4'd0,
  parameter logic [ADR_W-1:0] PWR_ADR  = 4'd2,
  parameter logic [ADR_W-1:0] PDG_ADR  = 4'd1,
  parameter logic [ADR_W-1:0] RFN_ADR  = 4'd4,
  parameter logic [ADR_W-1:0] IFN_ADR  = 4'd5,
  parameter logic [ADR_W-1:0] RFR_ADR  = 4'd7,
  parameter logic [ADR_W-1:0] IFR_ADR  = 4'd8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            sclk_o,
  output logic            sen_n_o,
  output logic            sdata_o
);

  localparam int FRAME_W = VAL_W + ADR_W;
  localparam int NREG    = 7;
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam int GAP_W   = $clog2(GAP + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP, S_DONE} state_t;

  state_t             state;
  logic [CH_W-1:0]    chan_q;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   divcnt;
  logic [GAP_W-1:0]   gapcnt;
  logic [BIT_W-1:0]   bitcnt;
  logic [VAL_W-1:0]   rfn;
  logic [FRAME_W-1:0] frame;

  assign rfn = (chan_q == CH_W'(SPECIAL_CH)) ? VAL_W'(SPECIAL_N)
             : VAL_W'(N_BASE) + VAL_W'(N_STEP) * VAL_W'(chan_q);

  always_comb begin
    case (idx)
      IDX_W'(0): frame = {MAIN_VAL, MAIN_ADR};
      IDX_W'(1): frame = {PWR_VAL,  PWR_ADR};
      IDX_W'(2): frame = {PDG_VAL,  PDG_ADR};
      IDX_W'(3): frame = {rfn,      RFN_ADR};
      IDX_W'(4): frame = {IFN_VAL,  IFN_ADR};
      IDX_W'(5): frame = {RFR_VAL,  RFR_ADR};
      default:   frame = {IFR_VAL,  IFR_ADR};
    endcase
  end

  assign busy_o  = (state != S_IDLE);
  assign done_o  = (state == S_DONE);
  assign sen_n_o = (state != S_SHIFT);
  assign sdata_o = (state == S_SHIFT) & shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      chan_q <= '0;
      idx    <= '0;
      shreg  <= '0;
      divcnt <= '0;
      gapcnt <= '0;
      bitcnt <= '0;
      sclk_o <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          chan_q <= chan_i;
          idx    <= '0;
          state  <= S_LOAD;
        end
        S_LOAD: begin
          shreg  <= frame;
          divcnt <= '0;
          bitcnt <= '0;
          sclk_o <= 1'b0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          if (divcnt == DIV_W'(HALF_DIV - 1)) begin
            divcnt <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
            end else begin
              sclk_o <= 1'b0;
              if (bitcnt == BIT_W'(FRAME_W - 1)) begin
                gapcnt <= '0;
                state  <= S_GAP;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= shreg << 1;
              end
            end
          end else begin
            divcnt <= divcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (gapcnt == GAP_W'(GAP - 1)) begin
            if (idx == IDX_W'(NREG - 1)) begin
              state <= S_DONE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LOAD;
            end
          end else begin
            gapcnt <= gapcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n_o |-> (!sclk_o && !sdata_o));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sen_n_o && !$stable(sdata_o)) |-> !sclk_o);

  // R6
  enable_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_n_o) |=> sen_n_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sen_n_o && busy_o));

  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(chan_q));

endmodule

// File: tb/synth_chan_seq_tb_top.sv
module synth_chan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV = 4;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [4:0] chan_i = '0;
  logic busy_o, done_o, sclk_o, sen_n_o, sdata_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
    .sen_n_o(sen_n_o), .sdata_o(sdata_o)
  );

  logic [21:0] frames [0:15];
  int nbits [0:15];
  int nf = 0;
  logic [21:0] cur = '0;
  int nb = 0;
  logic p_sclk = 1'b0, p_sen = 1'b1, p_sdata = 1'b0;
  int lvl_cnt = 0;
  int gap_cnt = 0;
  int done_cnt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (sen_n_o) begin
        chk(!sclk_o && !sdata_o, "R7 idle lines", {sclk_o, sdata_o}, 0);
      end
      if (!sen_n_o && sdata_o != p_sdata && !p_sen)
        chk(!sclk_o, "R5 data changes with clock low", sclk_o, 0);
      if (!sen_n_o && p_sen) begin
        if (nf > 0 && busy_o) chk(gap_cnt >= GAP, "R6 enable gap", gap_cnt, GAP);
        cur = '0; nb = 0; lvl_cnt = 0;
      end else if (!sen_n_o && sclk_o != p_sclk) begin
        chk(lvl_cnt >= HALF_DIV - 1, "R5 half period", lvl_cnt + 1, HALF_DIV);
        lvl_cnt = 0;
        if (sclk_o) begin cur = {cur[20:0], sdata_o}; nb++; end
      end else lvl_cnt++;
      if (sen_n_o && !p_sen) begin
        if (nf < 16) begin frames[nf] = cur; nbits[nf] = nb; end
        nf++;
        gap_cnt = 0;
      end
      if (sen_n_o) gap_cnt++;
      p_sclk = sclk_o; p_sen = sen_n_o; p_sdata = sdata_o;
    end
  end

  function automatic logic [21:0] exp_frame(input int i, input int ch);
    logic [17:0] v;
    logic [3:0] a;
    case (i)
      0: begin v = 18'h8;  a = 4'd0; end
      1: begin v = 18'h3;  a = 4'd2; end
      2: begin v = 18'h0;  a = 4'd1; end
      3: begin v = (ch == 14) ? 18'd2110 : 18'(2033 + 5 * ch); a = 4'd4; end
      4: begin v = 18'd1496; a = 4'd5; end
      5: begin v = 18'd44; a = 4'd7; end
      default: begin v = 18'd44; a = 4'd8; end
    endcase
    return {v, a};
  endfunction

  task automatic pulse_start(input int ch);
    @(negedge clk);
    start_i = 1'b1; chan_i = 5'(ch);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done_o) begin ok = 1; break; end
    end
  endtask

  task automatic check_seq(input int ch);
    chk(nf == 7, "R2 frame count", nf, 7);
    for (int i = 0; i < 7 && i < nf; i++) begin
      chk(nbits[i] == 22, "R1 bits per frame", nbits[i], 22);
      if (i == 3)
        chk(frames[i] == exp_frame(i, ch), "R3 RF N frame", frames[i], exp_frame(i, ch));
      else
        chk(frames[i] == exp_frame(i, ch), "R4 R2 fixed frame", frames[i], exp_frame(i, ch));
    end
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R10
    chk(sen_n_o && !sclk_o && !sdata_o && !busy_o && !done_o, "R10 reset state",
        {sen_n_o, sclk_o, sdata_o, busy_o, done_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(nf == 0 && sen_n_o, "R10 no frame before start", nf, 0);

    for (int ch = 0; ch < 32; ch++) begin
      nf = 0; done_cnt = 0;
      pulse_start(ch);
      chk(busy_o, "R8 busy after start", busy_o, 1);
      wait_done(ok);
      chk(ok, "R8 done seen", ok, 1);
      @(negedge clk);
      chk(!done_o && !busy_o && done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      check_seq(ch);
    end

    nf = 0; done_cnt = 0;
    pulse_start(3);
    repeat (300) @(negedge clk);
    pulse_start(20);   // R9 ignored while busy
    wait_done(ok);
    chk(ok, "R9 done after ignored start", ok, 1);
    repeat (400) @(negedge clk);
    chk(!busy_o && done_cnt == 1, "R9 no restart", done_cnt, 1);
    check_seq(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule